// File: doc/BRIEF.md
# Solid Rectangle Fill Engine

The block paints an axis-aligned rectangle of 8-bit pixels into a small frame memory that it holds itself. The fill value comes from a foreground colour register. A plane mask limits which bits of each pixel change. A pixel mask limits which columns are touched. Software enters the two rectangle corners by writing a Y register and then an X register, twice. It then launches the work by reading a draw register. The value returned tells software whether the engine took the job or whether it must read again.

While a fill runs, the engine writes one pixel per clock in row-major order. A status bit stays high for the whole operation. Corner coordinates are clamped to the frame size. A rectangle whose far corner is not strictly below and to the right of its near corner is taken and finishes at once without touching memory. A pixel window in the register map lets software, or a bench, read and write single pixels of the frame.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset the status busy bit is 0, the foreground colour reads 0, the pixel mask reads 0xFFFFFFFF, the plane mask reads 0xFF and every frame pixel is 0.
- R2: A write to RECT_Y (address 5) followed by a write to RECT_X (address 6) enters one corner. The first pair sets the inclusive near corner (x0,y0) and the second pair sets the exclusive far corner (x1,y1). An accepted fill sets exactly the pixels with x0<=x<x1 and y0<=y<y1, in increasing address order.
- R3: Bit 28 of STATUS (address 0) is 1 from the clock edge that accepts a fill until the last pixel is written. Back-to-back STATUS reads that start on the cycle after the accepting read return 1 exactly width*height times.
- R4: A read of DRAW (address 1) while busy returns 0xA0000000 and starts nothing. When idle, the read returns 0 and starts the rectangle entered since the last start, if both corners are complete.
- R5: For each pixel written, the bits set in the plane mask (address 4) take the foreground value (address 2) and the other bits keep their old value.
- R6: A pixel in column x is written only if bit (x mod 32) of the pixel mask (address 3) is 1. Masked pixels still take one cycle each.
- R7: If x1<=x0 or y1<=y0 after clamping, the DRAW read returns 0, busy never rises and no pixel changes.
- R8: Each X value is clamped to FRAME_W and each Y value to FRAME_H before use.
- R9: The ALU register (address 7) can be written and read back, but an XOR setting (bit 0 = 1) has no effect: a fill always replaces pixels.
- R10: While busy, every register write is ignored, including the corner and pixel-data writes.
- R11: PIXPOS (address 8) holds x in bits 15:0 and y in bits 31:16. PIXDATA (address 9) reads or writes that pixel. For a position outside the frame, reads return 0 and writes change nothing.
- R12: Read data appears on rd_data on the cycle after rd_en, and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after rd_en |

## Verification
The hardest situation to reach from the ports is a launch attempt, or a register write, landing while a fill is still in progress. The bench starts a full-frame fill, which keeps the engine busy for 128 cycles. Inside that window it reads DRAW a second time and writes both the colour and a fresh pair of corners. After the engine goes idle, it confirms that the colour is unchanged, that a further DRAW read starts nothing, and that the frame holds only the first fill. A position just past the right edge, which would alias onto the next row if left unchecked, exercises the pixel window's range guard.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
    localparam int          DATA_W      = 32;
    localparam int          ADDR_W      = 4;
    localparam int          MASK_BITS   = 32;
    localparam int          BUSY_BIT    = 28;
    localparam logic [31:0] REFUSE_WORD = 32'hA000_0000;

    localparam logic [ADDR_W-1:0] RA_STATUS  = 4'd0;
    localparam logic [ADDR_W-1:0] RA_DRAW    = 4'd1;
    localparam logic [ADDR_W-1:0] RA_FG      = 4'd2;
    localparam logic [ADDR_W-1:0] RA_PIXMASK = 4'd3;
    localparam logic [ADDR_W-1:0] RA_PLANE   = 4'd4;
    localparam logic [ADDR_W-1:0] RA_RECT_Y  = 4'd5;
    localparam logic [ADDR_W-1:0] RA_RECT_X  = 4'd6;
    localparam logic [ADDR_W-1:0] RA_ALU     = 4'd7;
    localparam logic [ADDR_W-1:0] RA_PIXPOS  = 4'd8;
    localparam logic [ADDR_W-1:0] RA_PIXDATA = 4'd9;
endpackage

// File: rtl/rfe_frame.sv
module rfe_frame #(
    parameter int DEPTH = 128,
    parameter int PIX_W = 8,
    parameter int AW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic [AW-1:0]    ra_addr,
    output logic [PIX_W-1:0] ra_data,
    input  logic [AW-1:0]    rb_addr,
    output logic [PIX_W-1:0] rb_data
);
    logic [PIX_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [PIX_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (we && (waddr == AW'(g)))
                word_d = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign words[g] = word_q;
    end

    assign ra_data = (int'(ra_addr) < DEPTH) ? words[ra_addr] : '0;
    assign rb_data = (int'(rb_addr) < DEPTH) ? words[rb_addr] : '0;
endmodule

// File: rtl/rfe_fill.sv
module rfe_fill
    import rfe_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int FRAME_H = 8,
    parameter int PIX_W   = 8,
    parameter int XW      = 5,
    parameter int YW      = 4,
    parameter int AW      = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [XW-1:0]        x0,
    input  logic [YW-1:0]        y0,
    input  logic [XW-1:0]        x1,
    input  logic [YW-1:0]        y1,
    input  logic [PIX_W-1:0]     fg,
    input  logic [MASK_BITS-1:0] pixm,
    input  logic [PIX_W-1:0]     plane,
    input  logic [PIX_W-1:0]     mem_rdata,
    output logic                 busy,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [PIX_W-1:0]     mem_wdata
);
    localparam int SELW = $clog2(MASK_BITS);

    typedef struct packed {
        logic          busy;
        logic [XW-1:0] cx;
        logic [YW-1:0] cy;
        logic [XW-1:0] left;
        logic [XW-1:0] xend;
        logic [YW-1:0] yend;
    } walk_t;

    walk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_addr  = AW'(int'(st_q.cy) * FRAME_W + int'(st_q.cx));
        mem_wdata = (mem_rdata & ~plane) | (fg & plane);
        if (st_q.busy) begin
            mem_we = pixm[SELW'(st_q.cx)];
            if (XW'(st_q.cx + 1'b1) == st_q.xend) begin
                st_d.cx = st_q.left;
                if (YW'(st_q.cy + 1'b1) == st_q.yend)
                    st_d.busy = 1'b0;
                else
                    st_d.cy = YW'(st_q.cy + 1'b1);
            end else begin
                st_d.cx = XW'(st_q.cx + 1'b1);
            end
        end else if (start && (x1 > x0) && (y1 > y0)) begin
            st_d.busy = 1'b1;
            st_d.cx   = x0;
            st_d.cy   = y0;
            st_d.left = x0;
            st_d.xend = x1;
            st_d.yend = y1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/rfe_regs.sv
module rfe_regs
    import rfe_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int FRAME_H = 8,
    parameter int PIX_W   = 8,
    parameter int XW      = 5,
    parameter int YW      = 4,
    parameter int AW      = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 busy,
    output logic                 start,
    output logic [XW-1:0]        x0,
    output logic [YW-1:0]        y0,
    output logic [XW-1:0]        x1,
    output logic [YW-1:0]        y1,
    output logic [PIX_W-1:0]     fg,
    output logic [MASK_BITS-1:0] pixm,
    output logic [PIX_W-1:0]     plane,
    output logic                 pix_we,
    output logic [AW-1:0]        pix_addr,
    output logic [PIX_W-1:0]     pix_wdata,
    input  logic [PIX_W-1:0]     pix_rdata
);
    typedef struct packed {
        logic [PIX_W-1:0]     fg;
        logic [MASK_BITS-1:0] pixm;
        logic [PIX_W-1:0]     plane;
        logic [DATA_W-1:0]    alu;
        logic [YW-1:0]        hold_y;
        logic [XW-1:0]        ax;
        logic [YW-1:0]        ay;
        logic [XW-1:0]        bx;
        logic [YW-1:0]        by;
        logic                 second;
        logic                 armed;
        logic [15:0]          pos_x;
        logic [15:0]          pos_y;
        logic [DATA_W-1:0]    rd;
    } regs_t;

    regs_t st_d, st_q;
    logic  pos_ok;

    function automatic logic [XW-1:0] clamp_x(input logic [15:0] v);
        if (v > 16'(FRAME_W)) return XW'(FRAME_W);
        return XW'(v);
    endfunction

    function automatic logic [YW-1:0] clamp_y(input logic [15:0] v);
        if (v > 16'(FRAME_H)) return YW'(FRAME_H);
        return YW'(v);
    endfunction

    assign pos_ok   = (st_q.pos_x < 16'(FRAME_W)) && (st_q.pos_y < 16'(FRAME_H));
    assign pix_addr = AW'(int'(st_q.pos_y) * FRAME_W + int'(st_q.pos_x));

    always_comb begin
        st_d      = st_q;
        start     = 1'b0;
        pix_we    = 1'b0;
        pix_wdata = wr_data[PIX_W-1:0];
        if (wr_en && !busy) begin
            case (addr)
                RA_FG:      st_d.fg     = wr_data[PIX_W-1:0];
                RA_PIXMASK: st_d.pixm   = wr_data[MASK_BITS-1:0];
                RA_PLANE:   st_d.plane  = wr_data[PIX_W-1:0];
                RA_ALU:     st_d.alu    = wr_data;
                RA_RECT_Y:  st_d.hold_y = clamp_y(wr_data[15:0]);
                RA_RECT_X: begin
                    if (!st_q.second) begin
                        st_d.ax     = clamp_x(wr_data[15:0]);
                        st_d.ay     = st_q.hold_y;
                        st_d.second = 1'b1;
                        st_d.armed  = 1'b0;
                    end else begin
                        st_d.bx     = clamp_x(wr_data[15:0]);
                        st_d.by     = st_q.hold_y;
                        st_d.second = 1'b0;
                        st_d.armed  = 1'b1;
                    end
                end
                RA_PIXPOS: begin
                    st_d.pos_x = wr_data[15:0];
                    st_d.pos_y = wr_data[31:16];
                end
                RA_PIXDATA: pix_we = pos_ok;
                default: ;
            endcase
        end
        if (rd_en) begin
            case (addr)
                RA_STATUS:  st_d.rd = DATA_W'({busy, {BUSY_BIT{1'b0}}});
                RA_DRAW: begin
                    if (busy) begin
                        st_d.rd = REFUSE_WORD;
                    end else begin
                        st_d.rd = '0;
                        if (st_q.armed) begin
                            start      = 1'b1;
                            st_d.armed = 1'b0;
                        end
                    end
                end
                RA_FG:      st_d.rd = DATA_W'(st_q.fg);
                RA_PIXMASK: st_d.rd = DATA_W'(st_q.pixm);
                RA_PLANE:   st_d.rd = DATA_W'(st_q.plane);
                RA_ALU:     st_d.rd = st_q.alu;
                RA_PIXPOS:  st_d.rd = {st_q.pos_y, st_q.pos_x};
                RA_PIXDATA: st_d.rd = pos_ok ? DATA_W'(pix_rdata) : '0;
                default:    st_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.pixm  <= '1;
            st_q.plane <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;
    assign x0      = st_q.ax;
    assign y0      = st_q.ay;
    assign x1      = st_q.bx;
    assign y1      = st_q.by;
    assign fg      = st_q.fg;
    assign pixm    = st_q.pixm;
    assign plane   = st_q.plane;
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
    import rfe_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int FRAME_H = 8,
    parameter int PIX_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = FRAME_W * FRAME_H;
    localparam int XW    = $clog2(FRAME_W + 1);
    localparam int YW    = $clog2(FRAME_H + 1);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic                 fill_busy, fill_start, fill_we, pix_we;
    logic [XW-1:0]        cx0, cx1;
    logic [YW-1:0]        cy0, cy1;
    logic [PIX_W-1:0]     fg, plane, fill_wdata, fill_rdata, pix_wdata, pix_rdata;
    logic [MASK_BITS-1:0] pixm;
    logic [AW-1:0]        fill_addr, pix_addr;
    logic                 mem_we;
    logic [AW-1:0]        mem_waddr;
    logic [PIX_W-1:0]     mem_wdata;

    rfe_regs #(
        .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .PIX_W(PIX_W),
        .XW(XW), .YW(YW), .AW(AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .busy(fill_busy), .start(fill_start),
        .x0(cx0), .y0(cy0), .x1(cx1), .y1(cy1), .fg(fg), .pixm(pixm), .plane(plane),
        .pix_we(pix_we), .pix_addr(pix_addr), .pix_wdata(pix_wdata), .pix_rdata(pix_rdata)
    );

    rfe_fill #(
        .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .PIX_W(PIX_W),
        .XW(XW), .YW(YW), .AW(AW)
    ) u_fill (
        .clk(clk), .rst_n(rst_n), .start(fill_start),
        .x0(cx0), .y0(cy0), .x1(cx1), .y1(cy1), .fg(fg), .pixm(pixm), .plane(plane),
        .mem_rdata(fill_rdata), .busy(fill_busy), .mem_we(fill_we),
        .mem_addr(fill_addr), .mem_wdata(fill_wdata)
    );

    assign mem_we    = fill_we | pix_we;
    assign mem_waddr = fill_busy ? fill_addr  : pix_addr;
    assign mem_wdata = fill_busy ? fill_wdata : pix_wdata;

    rfe_frame #(.DEPTH(DEPTH), .PIX_W(PIX_W), .AW(AW)) u_frame (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .ra_addr(fill_addr), .ra_data(fill_rdata),
        .rb_addr(pix_addr), .rb_data(pix_rdata)
    );
endmodule

// File: rtl/rfe_chk.sv
module rfe_chk
    import rfe_pkg::*;
#(
    parameter int AW = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy,
    input logic              fill_we,
    input logic [AW-1:0]     fill_addr,
    input logic              pix_we
);
    // R4
    draw_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RA_DRAW && busy) |=> (rd_data == REFUSE_WORD));

    // R3
    status_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RA_STATUS) |=> (rd_data[BUSY_BIT] == $past(busy)));

    // R3
    fill_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> busy);

    // R2
    row_major_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (fill_addr > $past(fill_addr)));

    // R10
    bus_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> !busy);
endmodule

bind rect_fill_engine rfe_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rd_data(rd_data),
    .busy(fill_busy), .fill_we(fill_we), .fill_addr(fill_addr), .pix_we(pix_we)
);

// File: tb/sim_rect_fill_engine.sv
module sim_rect_fill_engine;
    import rfe_pkg::*;

    localparam int W = 16;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    logic [7:0]  model [H][W];
    logic [7:0]  m_fg = 8'h00;
    logic [31:0] m_pixm = 32'hFFFF_FFFF;
    logic [7:0]  m_plane = 8'hFF;

    always #10 clk = ~clk;

    rect_fill_engine #(.FRAME_W(W), .FRAME_H(H), .PIX_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        #2 d = rd_data;
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_rect(input int x0, input int y0, input int x1, input int y1);
        bus_wr(RA_RECT_Y, 32'(y0));
        bus_wr(RA_RECT_X, 32'(x0));
        bus_wr(RA_RECT_Y, 32'(y1));
        bus_wr(RA_RECT_X, 32'(x1));
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] s;
        cyc = 0;
        forever begin
            bus_rd(RA_STATUS, s);
            if (!s[28] || cyc > 1000) break;
            cyc++;
        end
    endtask

    task automatic model_fill(input int x0, input int y0, input int x1, input int y1);
        int a0 = (x0 > W) ? W : x0;
        int a1 = (x1 > W) ? W : x1;
        int b0 = (y0 > H) ? H : y0;
        int b1 = (y1 > H) ? H : y1;
        for (int y = b0; y < b1; y++)
            for (int x = a0; x < a1; x++)
                if (m_pixm[x % 32])
                    model[y][x] = (model[y][x] & ~m_plane) | (m_fg & m_plane);
    endtask

    task automatic fill_and_check(input int x0, input int y0, input int x1, input int y1,
                                  input int exp_cyc, input string req);
        logic [31:0] d;
        int cyc;
        set_rect(x0, y0, x1, y1);
        bus_rd(RA_DRAW, d);
        chk(d == 32'h0, "R4 idle draw read accepted", d, 32'h0);
        wait_idle(cyc);
        chk(cyc == exp_cyc, {req, " busy cycles"}, 32'(cyc), 32'(exp_cyc));
        model_fill(x0, y0, x1, y1);
    endtask

    task automatic check_frame(input string req);
        logic [31:0] d;
        int bad = 0;
        logic [31:0] fa = 0, fe = 0;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                bus_wr(RA_PIXPOS, {16'(y), 16'(x)});
                bus_rd(RA_PIXDATA, d);
                if (d != 32'(model[y][x])) begin
                    if (bad == 0) begin fa = d; fe = 32'(model[y][x]); end
                    bad++;
                end
            end
        chk(bad == 0, {req, " frame contents"}, fa, fe);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(RA_STATUS, d);  chk(d == 0, "R1 status after reset", d, 0);
        bus_rd(RA_FG, d);      chk(d == 0, "R1 fg after reset", d, 0);
        bus_rd(RA_PIXMASK, d); chk(d == 32'hFFFF_FFFF, "R1 pixel mask after reset", d, 32'hFFFF_FFFF);
        bus_rd(RA_PLANE, d);   chk(d == 32'hFF, "R1 R12 plane mask after reset", d, 32'hFF);
        check_frame("R1");
    endtask

    task automatic t_basic();
        m_fg = 8'h5A;
        bus_wr(RA_FG, 32'h5A);
        fill_and_check(2, 1, 7, 4, 15, "R3");
        check_frame("R2");
    endtask

    task automatic t_refuse();
        logic [31:0] d;
        int cyc;
        m_fg = 8'h11;
        bus_wr(RA_FG, 32'h11);
        set_rect(0, 0, 16, 8);
        bus_rd(RA_DRAW, d);
        chk(d == 0, "R4 first draw accepted", d, 0);
        bus_rd(RA_DRAW, d);
        chk(d == REFUSE_WORD, "R4 draw while busy refused", d, REFUSE_WORD);
        bus_wr(RA_FG, 32'h99);
        set_rect(0, 0, 4, 4);
        wait_idle(cyc);
        model_fill(0, 0, 16, 8);
        bus_rd(RA_FG, d);
        chk(d == 32'h11, "R10 fg write while busy ignored", d, 32'h11);
        bus_rd(RA_DRAW, d);
        bus_rd(RA_STATUS, d);
        chk(d[28] == 1'b0, "R10 corner writes while busy ignored", d, 0);
        check_frame("R4");
    endtask

    task automatic t_plane();
        m_plane = 8'h0F; m_fg = 8'hA6;
        bus_wr(RA_PLANE, 32'h0F);
        bus_wr(RA_FG, 32'hA6);
        fill_and_check(3, 2, 6, 5, 9, "R5");
        check_frame("R5");
        m_plane = 8'hFF;
        bus_wr(RA_PLANE, 32'hFF);
    endtask

    task automatic t_pixmask();
        m_pixm = 32'h0000_5555; m_fg = 8'h42;
        bus_wr(RA_PIXMASK, 32'h0000_5555);
        bus_wr(RA_FG, 32'h42);
        fill_and_check(0, 6, 16, 8, 32, "R6");
        check_frame("R6");
        m_pixm = 32'hFFFF_FFFF;
        bus_wr(RA_PIXMASK, 32'hFFFF_FFFF);
    endtask

    task automatic t_empty();
        m_fg = 8'hEE;
        bus_wr(RA_FG, 32'hEE);
        fill_and_check(5, 5, 5, 7, 0, "R7 zero width");
        fill_and_check(9, 3, 4, 6, 0, "R7 reversed x");
        fill_and_check(2, 6, 8, 2, 0, "R7 reversed y");
        check_frame("R7");
    endtask

    task automatic t_clamp();
        m_fg = 8'h7E;
        bus_wr(RA_FG, 32'h7E);
        fill_and_check(12, 5, 100, 50, 12, "R8");
        check_frame("R8");
    endtask

    task automatic t_xor();
        logic [31:0] d;
        bus_wr(RA_ALU, 32'h1);
        bus_rd(RA_ALU, d);
        chk(d == 32'h1, "R9 alu readback", d, 32'h1);
        m_fg = 8'h0F;
        bus_wr(RA_FG, 32'h0F);
        fill_and_check(0, 0, 2, 2, 4, "R9");
        check_frame("R9");
    endtask

    task automatic t_pixport();
        logic [31:0] d;
        bus_wr(RA_PIXPOS, {16'd0, 16'd16});
        bus_wr(RA_PIXDATA, 32'h77);
        bus_rd(RA_PIXDATA, d);
        chk(d == 0, "R11 out-of-range read", d, 0);
        bus_wr(RA_PIXPOS, {16'd7, 16'd3});
        bus_wr(RA_PIXDATA, 32'h3C);
        bus_rd(RA_PIXDATA, d);
        chk(d == 32'h3C, "R11 R12 in-range readback", d, 32'h3C);
        model[7][3] = 8'h3C;
        check_frame("R11");
    endtask

    initial begin
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                model[y][x] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_refuse();
        t_plane();
        t_pixmask();
        t_empty();
        t_clamp();
        t_xor();
        t_pixport();
        summary();
        $finish;
    end
endmodule